// File: doc/BRIEF.md
# Full-Duplex I2S Master Transceiver

This block is the clock master for a stereo serial audio link. It divides a system clock that runs at twice the master audio clock, producing a master clock at 256 times the sample rate, a bit clock at a quarter of that, and a word-select line with one period per frame. Playback pairs of 16-bit samples are accepted in parallel through a once-per-frame ready/valid handshake and shifted out. A serial input sharing the same clocks is shifted in, and each captured stereo pair is presented with a one-cycle valid strobe.

Attached converters or DSPs run as slaves. Each playback pair also appears on a parallel port for an on-chip converter, at the moment it is loaded for transmission. A mono capture mode records only the left slot.

The format is standard I2S. There are 64 bit clocks per frame, in two 32-bit slots. The left slot is sent while word select is low. Each 16-bit sample is sent MSB first in the upper half of its slot, starting one bit clock after the word-select edge.

Top module: `i2s_duplex_master`

## Requirements
- R1: `mclk` toggles on every `clk` cycle, and is low in frame cycle 0. `bclk` is high in frame cycles where bit 2 of the cycle index is set (period 8 `clk`). A frame is 512 `clk` cycles long, and frame cycle 0 is the first cycle after reset is released.
- R2: In bit period b = cycle/8, `lrck` is 1 exactly when (b+1) mod 64 is 32 or more. It is low for the left slot and changes only where `bclk` falls, one bit clock before each slot's MSB.
- R3: `sdout` changes only where `bclk` falls. In bit period b, the slot is left for b < 32 and right otherwise, and the position p is b mod 32. For p < 16 the output is sample bit 15-p; for p of 16 or more it is 0.
- R4: `txReady` is high only in frame cycle 511. A pair with `txValid` high in that cycle is sent in the next frame.
- R5: If `txValid` is low in frame cycle 511, the previous pair is sent again in the next frame.
- R6: `dacStrobe` is high only in frame cycle 0 of every frame after the first. In that cycle `dacLeft`/`dacRight` hold the pair being transmitted in that frame.
- R7: `sdin` is sampled while `bclk` is high. In each slot, positions 0 to 15 form the captured sample, MSB first, and positions 16 to 31 are ignored.
- R8: `rxValid` is high only in frame cycle 381, with that frame's pair on `rxLeft`/`rxRight`. Both outputs hold their values until the next strobe.
- R9: When `monoMode` is 1, `rxRight` equals `rxLeft`, which is the left-slot sample. The right slot's data has no effect.
- R10: While `rst` is high, `mclk`, `bclk`, `lrck`, `sdout`, `txReady`, `dacStrobe`, `rxValid` and all sample outputs are 0. The first frame after reset starts with the left slot and transmits zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at twice the master audio clock |
| rst | input | 1 | Synchronous reset, active high |
| monoMode | input | 1 | 1 = capture the left slot into both outputs |
| txValid | input | 1 | Playback pair on txLeft/txRight is valid |
| txLeft | input | 16 | Left playback sample |
| txRight | input | 16 | Right playback sample |
| txReady | output | 1 | Pair is taken in this cycle if txValid |
| dacLeft | output | 16 | Left sample now being transmitted |
| dacRight | output | 16 | Right sample now being transmitted |
| dacStrobe | output | 1 | New parallel playback pair, one cycle |
| mclk | output | 1 | Master clock, 256 fs |
| bclk | output | 1 | Bit clock, 64 fs |
| lrck | output | 1 | Word select, low = left |
| sdout | output | 1 | Serial playback data |
| sdin | input | 1 | Serial capture data |
| rxLeft | output | 16 | Captured left sample |
| rxRight | output | 16 | Captured right sample (left in mono mode) |
| rxValid | output | 1 | Captured pair valid, one cycle |

## Verification
The bench drives random noise into the unused lower half of each capture slot. A receiver that shifted all 32 positions, or took the sample one bit late, would return corrupted pairs. Extreme sample values (only the MSB set, only the LSB set, all ones) expose bit-order or slot-offset mistakes. A missing one-bit delay after the word-select edge would shift every word by one position.

Frames without a valid pair check that the previous pair repeats and is not cleared. Mono frames carry random right-slot data that must not appear on `rxRight`. A reset in mid-stream checks that word select restarts low, that transmission restarts from zero, and that the first frame starts with the left slot.

// File: rtl/i2s_duplex_pkg.sv
package i2s_duplex_pkg;

  // Strobes from the frame sequencer to the serial datapath
  typedef struct packed {
    logic frameEnd;     // last clk cycle of a frame
    logic txShiftEn;    // next edge starts a new bit period
    logic rxSample;     // bit clock high, slot position carries sample data
    logic rxLeftDone;   // sampling the left LSB
    logic rxRightDone;  // sampling the right LSB
  } i2sStrobes_t;

endpackage

// File: rtl/i2s_clock_ctrl.sv
module i2s_clock_ctrl
  import i2s_duplex_pkg::*;
#(
  parameter int CLK_PER_MCLK  = 2,
  parameter int MCLK_PER_BCLK = 4,
  parameter int SLOT_W        = 32,
  parameter int SAMPLE_W      = 16
) (
  input  logic        clk,
  input  logic        rst,
  output logic        mclk,
  output logic        bclk,
  output logic        lrck,
  output i2sStrobes_t stb
);

  localparam int CLK_PER_BCLK = CLK_PER_MCLK * MCLK_PER_BCLK;
  localparam int PH_W         = $clog2(CLK_PER_BCLK);
  localparam int SLOT_BITS    = $clog2(SLOT_W);
  localparam int CNT_W        = PH_W + SLOT_BITS + 1;
  localparam int MCLK_BIT     = $clog2(CLK_PER_MCLK) - 1;
  localparam int LR_RISE      = (SLOT_W - 1) * CLK_PER_BCLK - 1;
  localparam int LR_FALL      = (2 * SLOT_W - 1) * CLK_PER_BCLK - 1;
  localparam int SAMPLE_PH    = CLK_PER_BCLK / 2;

  logic [CNT_W-1:0]     frameCnt;
  logic [PH_W-1:0]      phase;
  logic [SLOT_BITS:0]   bitIdx;
  logic [SLOT_BITS-1:0] slotPos;
  logic                 inRight;
  logic                 sampleNow;
  logic                 lrckQ;

  assign phase   = frameCnt[PH_W-1:0];
  assign bitIdx  = frameCnt[CNT_W-1:PH_W];
  assign slotPos = bitIdx[SLOT_BITS-1:0];
  assign inRight = bitIdx[SLOT_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      frameCnt <= '0;
      lrckQ    <= 1'b0;
    end else begin
      frameCnt <= frameCnt + 1'b1;
      // word select moves one bit period ahead of each slot
      if (frameCnt == CNT_W'(LR_RISE))      lrckQ <= 1'b1;
      else if (frameCnt == CNT_W'(LR_FALL)) lrckQ <= 1'b0;
    end
  end

  assign mclk = frameCnt[MCLK_BIT];
  assign bclk = frameCnt[PH_W-1];
  assign lrck = lrckQ;

  assign sampleNow = (phase == PH_W'(SAMPLE_PH));

  always_comb begin
    stb             = '0;
    stb.frameEnd    = &frameCnt;
    stb.txShiftEn   = &phase;
    stb.rxSample    = sampleNow && (int'(slotPos) < SAMPLE_W);
    stb.rxLeftDone  = sampleNow && !inRight && (slotPos == SLOT_BITS'(SAMPLE_W - 1));
    stb.rxRightDone = sampleNow &&  inRight && (slotPos == SLOT_BITS'(SAMPLE_W - 1));
  end

endmodule

// File: rtl/i2s_serial_path.sv
module i2s_serial_path
  import i2s_duplex_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  i2sStrobes_t         stb,
  input  logic                monoMode,
  input  logic                txValid,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                txReady,
  output logic [SAMPLE_W-1:0] dacLeft,
  output logic [SAMPLE_W-1:0] dacRight,
  output logic                dacStrobe,
  output logic                sdout,
  input  logic                sdin,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);

  localparam int FRAME_W = 2 * SLOT_W;
  localparam int PAD_W   = SLOT_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] heldLeft, heldRight, nextLeft, nextRight;
  logic [FRAME_W-1:0]  txShift, loadWord;
  logic [SAMPLE_W-1:0] rxShift, rxWord, leftHold;
  logic                accept;

  assign txReady   = stb.frameEnd;
  assign accept    = txReady && txValid;
  assign nextLeft  = accept ? txLeft  : heldLeft;
  assign nextRight = accept ? txRight : heldRight;

  generate
    if (PAD_W > 0) begin : g_padded
      assign loadWord = {nextLeft, {PAD_W{1'b0}}, nextRight, {PAD_W{1'b0}}};
    end else begin : g_packed
      assign loadWord = {nextLeft, nextRight};
    end
  endgenerate

  // playback: one frame-wide shift register, MSB leaves first
  always_ff @(posedge clk) begin
    if (rst) begin
      txShift   <= '0;
      heldLeft  <= '0;
      heldRight <= '0;
      dacStrobe <= 1'b0;
    end else begin
      dacStrobe <= stb.frameEnd;
      if (stb.frameEnd) begin
        heldLeft  <= nextLeft;
        heldRight <= nextRight;
        txShift   <= loadWord;
      end else if (stb.txShiftEn) begin
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign sdout    = txShift[FRAME_W-1];
  assign dacLeft  = heldLeft;
  assign dacRight = heldRight;

  // capture: only the sample positions of each slot enter the shifter
  assign rxWord = {rxShift[SAMPLE_W-2:0], sdin};

  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift  <= '0;
      leftHold <= '0;
      rxLeft   <= '0;
      rxRight  <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (stb.rxSample) rxShift <= rxWord;
      if (stb.rxLeftDone) leftHold <= rxWord;
      if (stb.rxRightDone) begin
        rxLeft  <= leftHold;
        rxRight <= monoMode ? leftHold : rxWord;
        rxValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2s_duplex_master.sv
module i2s_duplex_master
  import i2s_duplex_pkg::*;
#(
  parameter int CLK_PER_MCLK  = 2,
  parameter int MCLK_PER_BCLK = 4,
  parameter int SLOT_W        = 32,
  parameter int SAMPLE_W      = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                monoMode,
  input  logic                txValid,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                txReady,
  output logic [SAMPLE_W-1:0] dacLeft,
  output logic [SAMPLE_W-1:0] dacRight,
  output logic                dacStrobe,
  output logic                mclk,
  output logic                bclk,
  output logic                lrck,
  output logic                sdout,
  input  logic                sdin,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);

  i2sStrobes_t stb;

  i2s_clock_ctrl #(
    .CLK_PER_MCLK (CLK_PER_MCLK),
    .MCLK_PER_BCLK(MCLK_PER_BCLK),
    .SLOT_W       (SLOT_W),
    .SAMPLE_W     (SAMPLE_W)
  ) u_ctrl (
    .clk (clk),
    .rst (rst),
    .mclk(mclk),
    .bclk(bclk),
    .lrck(lrck),
    .stb (stb)
  );

  i2s_serial_path #(
    .SAMPLE_W(SAMPLE_W),
    .SLOT_W  (SLOT_W)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .monoMode (monoMode),
    .txValid  (txValid),
    .txLeft   (txLeft),
    .txRight  (txRight),
    .txReady  (txReady),
    .dacLeft  (dacLeft),
    .dacRight (dacRight),
    .dacStrobe(dacStrobe),
    .sdout    (sdout),
    .sdin     (sdin),
    .rxLeft   (rxLeft),
    .rxRight  (rxRight),
    .rxValid  (rxValid)
  );

endmodule

// File: rtl/i2s_duplex_checker.sv
module i2s_duplex_checker #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                monoMode,
  input logic                txValid,
  input logic [SAMPLE_W-1:0] txLeft,
  input logic                txReady,
  input logic [SAMPLE_W-1:0] dacLeft,
  input logic                dacStrobe,
  input logic                mclk,
  input logic                bclk,
  input logic                lrck,
  input logic                sdout,
  input logic [SAMPLE_W-1:0] rxLeft,
  input logic [SAMPLE_W-1:0] rxRight,
  input logic                rxValid
);

  a_r1_mclk_toggles: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mclk != $past(mclk)));

  a_r2_lrck_on_bclk_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrck) |-> $fell(bclk));

  a_r3_sdout_on_bclk_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdout) |-> $fell(bclk));

  a_r4_ready_single: assert property (@(posedge clk) disable iff (rst)
    txReady |=> !txReady);

  a_r5_repeat_pair: assert property (@(posedge clk) disable iff (rst)
    (txReady && !txValid) |=> (dacLeft == $past(dacLeft)));

  a_r6_load_pair: assert property (@(posedge clk) disable iff (rst)
    (txReady && txValid) |=> (dacStrobe && dacLeft == $past(txLeft)));

  a_r6_strobe_follows_ready: assert property (@(posedge clk) disable iff (rst)
    dacStrobe |-> $past(txReady));

  a_r8_rx_pulse: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  a_r8_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !rxValid) |-> ($stable(rxLeft) && $stable(rxRight)));

  a_r9_mono_copy: assert property (@(posedge clk) disable iff (rst)
    (rxValid && $past(monoMode)) |-> (rxLeft == rxRight));

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!mclk && !bclk && !lrck && !sdout && !rxValid && !dacStrobe));

endmodule

bind i2s_duplex_master i2s_duplex_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .monoMode (monoMode),
  .txValid  (txValid),
  .txLeft   (txLeft),
  .txReady  (txReady),
  .dacLeft  (dacLeft),
  .dacStrobe(dacStrobe),
  .mclk     (mclk),
  .bclk     (bclk),
  .lrck     (lrck),
  .sdout    (sdout),
  .rxLeft   (rxLeft),
  .rxRight  (rxRight),
  .rxValid  (rxValid)
);

// File: tb/sim_i2s_duplex_master.sv
module sim_i2s_duplex_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        monoMode = 1'b0;
  logic        txValid = 1'b0;
  logic [15:0] txLeft = '0, txRight = '0;
  logic        txReady, dacStrobe, mclk, bclk, lrck, sdout, rxValid;
  logic        sdin = 1'b0;
  logic [15:0] dacLeft, dacRight, rxLeft, rxRight;

  always #10 clk = ~clk;

  i2s_duplex_master u0 (
    .clk(clk), .rst(rst), .monoMode(monoMode), .txValid(txValid),
    .txLeft(txLeft), .txRight(txRight), .txReady(txReady),
    .dacLeft(dacLeft), .dacRight(dacRight), .dacStrobe(dacStrobe),
    .mclk(mclk), .bclk(bclk), .lrck(lrck), .sdout(sdout), .sdin(sdin),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid)
  );

  int nChecks = 0;
  int nFail   = 0;
  int fc      = 0;
  int frameNo = 0;
  logic [15:0] frameL, frameR, nextL, nextR, sendL, sendR, lastRxL, lastRxR;
  bit monoNow, repeatNow, repeatNext, haveRx;

  // frame cycle index, cycle 0 = first cycle after reset release
  always @(posedge clk) begin
    if (rst) fc <= 0;
    else     fc <= (fc + 1) % 512;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at frame cycle %0d: actual %0h expected %0h", tag, fc, act, exp);
    end
  endtask

  function automatic bit expSdout(input int f);
    int b   = f / 8;
    int pos = b % 32;
    if (pos >= 16) return 1'b0;
    return (b >= 32) ? frameR[15-pos] : frameL[15-pos];
  endfunction

  task automatic driveSdin(input int f);
    int b   = f / 8;
    int pos = b % 32;
    if (pos < 16) sdin = (b >= 32) ? sendR[15-pos] : sendL[15-pos];
    else          sdin = 1'($urandom % 2);   // R7: padding is noise
  endtask

  // stimulus for one frame: capture pair, playback offer, mono select
  task automatic startFrame();
    case (frameNo)
      0: begin sendL = 16'h8000; sendR = 16'h0001; txValid = 1; txLeft = 16'hFFFF; txRight = 16'h0000; monoNow = 0; end
      1: begin sendL = 16'h7FFF; sendR = 16'hFFFF; txValid = 1; txLeft = 16'h8001; txRight = 16'h0001; monoNow = 0; end
      2: begin sendL = 16'h1234; sendR = 16'hABCD; txValid = 0; txLeft = 16'h0BAD; txRight = 16'hBEEF; monoNow = 1; end
      3: begin sendL = 16'h0001; sendR = 16'h8000; txValid = 0; txLeft = 16'h5555; txRight = 16'hAAAA; monoNow = 1; end
      default: begin
        sendL   = 16'($urandom);
        sendR   = 16'($urandom);
        txValid = ($urandom % 4) != 0;
        txLeft  = 16'($urandom);
        txRight = 16'($urandom);
        monoNow = ($urandom % 3) == 0;
      end
    endcase
    monoMode = monoNow;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      check(mclk == 0 && bclk == 0 && lrck == 0, "R10 clocks low", {mclk, bclk, lrck}, 0);
      check(sdout == 0 && txReady == 0 && dacStrobe == 0 && rxValid == 0, "R10 strobes low",
            {sdout, txReady, dacStrobe, rxValid}, 0);
      check(rxLeft == 0 && rxRight == 0 && dacLeft == 0 && dacRight == 0, "R10 samples clear",
            int'(rxLeft | rxRight | dacLeft | dacRight), 0);
      frameL = '0; frameR = '0; nextL = '0; nextR = '0;
      repeatNext = 0; haveRx = 0;
      startFrame();
      driveSdin(0);
    end else begin
      if (fc == 0) begin
        frameL = nextL; frameR = nextR; repeatNow = repeatNext;
        frameNo++;
        startFrame();
        check(dacStrobe == 1, "R6 strobe at frame start", dacStrobe, 1);
        check(dacLeft == frameL && dacRight == frameR, repeatNow ? "R5 repeated pair" : "R6 parallel pair",
              {dacLeft, dacRight}, {frameL, frameR});
      end else begin
        check(dacStrobe == 0, "R6 strobe only at start", dacStrobe, 0);
      end
      if (fc % 8 == 0) driveSdin(fc);
      check(mclk == fc[0], "R1 mclk", mclk, fc[0]);
      check(bclk == fc[2], "R1 bclk", bclk, fc[2]);
      check(lrck == (((fc / 8 + 1) % 64) >= 32), "R2 lrck", lrck, (((fc / 8 + 1) % 64) >= 32));
      check(sdout == expSdout(fc), repeatNow ? "R5 sdout repeat" : "R3 sdout", sdout, expSdout(fc));
      check(txReady == (fc == 511), "R4 txReady", txReady, fc == 511);
      if (fc == 511) begin
        if (txValid) begin nextL = txLeft; nextR = txRight; repeatNext = 0; end
        else repeatNext = 1;
      end
      check(rxValid == (fc == 381), "R8 rxValid", rxValid, fc == 381);
      if (fc == 381) begin
        check(rxLeft == sendL, "R7 left capture", rxLeft, sendL);
        if (monoNow) check(rxRight == sendL, "R9 mono right", rxRight, sendL);
        else         check(rxRight == sendR, "R7 right capture", rxRight, sendR);
        lastRxL = rxLeft; lastRxR = rxRight; haveRx = 1;
      end
      if (fc == 200 && haveRx)
        check(rxLeft == lastRxL && rxRight == lastRxR, "R8 hold", {rxLeft, rxRight}, {lastRxL, lastRxR});
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    repeat (30 * 512) @(negedge clk);
    // reset in mid-stream: clocks stop low, next frame restarts at left slot with zeros
    #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    repeat (10 * 512) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule